// File: doc/BRIEF.md
# Conditional Stream Output Compressor

A row of parallel lanes each produce one result per access, together with a local write-enable flag. This block packs only the flagged results into a dense output stream. The stream has no gaps. It is written to the stream store as whole rows of `NUM_LANES` words, so a sparse set of lane results is compacted without passing through memory.

Each access takes two pipeline steps. In the first cycle the flags are turned into control: every enabled lane receives a rank, which is the number of enabled lanes below it, and the access as a whole receives a word count. In the second cycle a lane-to-slot crossbar writes each enabled value into a staging buffer of `2*NUM_LANES` slots, which forms two sides. The slot is chosen by the fill pointer plus the lane's rank, taken modulo `2*NUM_LANES`. When a side holds `NUM_LANES` words, that side goes out as one wide write and filling continues in the other side.

Finishing the stream is requested with `finish_i`. If the current side is only partly filled, its empty slots are padded with `null_val_i` and the side is written. After the last write `done_o` pulses for one cycle. `total_o` then holds the number of real words in the stream.

Top module: `cso_compressor`

## Requirements
- R1: After reset, `stream_we_o` and `done_o` are low and `total_o` is zero.
- R2: The stream holds only lanes whose `wen_i` bit is set. Within one access lower lanes come first, and accesses appear in the order they were accepted. Bus slot k of `stream_data_o` (bits k*DATA_W upward) carries the k-th word of that write.
- R3: An access that completes a side raises `stream_we_o` in the cycle that follows the second rising edge after the access was sampled.
- R4: Every wide write carries exactly `NUM_LANES` words. `stream_we_o` is high for exactly one cycle per completed side. There is no write in cycles that have no access, finish or pending tail behind them.
- R5: When `finish_i` is accepted while the current side holds r words (0 < r < NUM_LANES), that side is written. Slots r and above carry the `null_val_i` value that was sampled together with `finish_i`. `done_o` follows within three cycles of the finish.
- R6: When `finish_i` is accepted with the current side empty, no padded write occurs and `done_o` pulses alone.
- R7: An access that arrives in the same cycle as `finish_i` is included in the stream ahead of the padding.
- R8: `done_o` is a single-cycle pulse that occurs once per finish, in the same cycle as the final write. If an access completes one side and also leaves words in the next side, the full write comes first and the padded write with `done_o` comes in the following cycle.
- R9: `total_o` counts the enabled words accepted since the start of the stream. It holds its value after `done_o` until the next accepted access, which restarts the count.
- R10: `valid_i` and `finish_i` are ignored from the cycle after a finish is accepted until `done_o` is asserted.
- R11: An access with no flag set adds nothing to the stream and leaves the fill position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access strobe for this cycle |
| wen_i | input | NUM_LANES | Per-lane write-enable flags |
| lane_data_i | input | NUM_LANES*DATA_W | Lane results, lane 0 in the low bits |
| finish_i | input | 1 | End of stream: pad and flush |
| null_val_i | input | DATA_W | Padding value, sampled with finish_i |
| stream_we_o | output | 1 | Wide write strobe to the stream store |
| stream_data_o | output | NUM_LANES*DATA_W | One full side of stream words |
| done_o | output | 1 | Pulses with (or as) the final write of a stream |
| total_o | output | TOTAL_W | Real words written in the current or last stream |

## Verification
In the hardest case, a side flush and the end-of-stream padding fall due in the same cycle. This happens when `finish_i` comes with an access whose words run past the side boundary. The bench provokes it by sweeping every pair of flag masks for two accesses, with the finish either concurrent with the second access or issued on its own. Each case is judged by checking the full row and then the padded row one cycle later against a queue of words computed in the bench, and by requiring `done_o` only once that queue is empty.

// File: rtl/cso_pkg.sv
package cso_pkg;
  typedef enum logic [1:0] {
    FL_IDLE = 2'd0,
    FL_FULL = 2'd1,
    FL_PAD  = 2'd2,
    FL_TAIL = 2'd3
  } flush_e;
endpackage

// File: rtl/cso_rank.sv
module cso_rank #(
  parameter int N      = 4,
  parameter int RANK_W = 2,
  parameter int CNT_W  = 3
) (
  input  logic [N-1:0]        wen_i,
  output logic [N*RANK_W-1:0] rank_o,
  output logic [CNT_W-1:0]    cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [RANK_W-1:0] r;
    always_comb begin
      r = '0;
      for (int k = 0; k < N; k++) begin
        if (k < i && wen_i[k]) r = r + RANK_W'(1);
      end
    end
    assign rank_o[i*RANK_W +: RANK_W] = r;
  end

  always_comb begin
    cnt_o = '0;
    for (int k = 0; k < N; k++) begin
      if (wen_i[k]) cnt_o = cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cso_xbar.sv
module cso_xbar #(
  parameter int N      = 4,
  parameter int W      = 8,
  parameter int SLOT_W = 3,
  parameter int RANK_W = 2
) (
  input  logic [SLOT_W-1:0]   ptr_i,
  input  logic [N-1:0]        wen_i,
  input  logic [N*RANK_W-1:0] rank_i,
  input  logic [N*W-1:0]      lane_data_i,
  input  logic [2*N*W-1:0]    buf_i,
  output logic [2*N*W-1:0]    buf_o
);
  localparam int SLOTS = 2 * N;

  logic [SLOT_W-1:0] dest [N];

  for (genvar i = 0; i < N; i++) begin : g_dest
    // wraps modulo 2N because 2N is a power of two
    assign dest[i] = ptr_i + SLOT_W'(rank_i[i*RANK_W +: RANK_W]);
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic [W-1:0] word;
    always_comb begin
      word = buf_i[j*W +: W];
      for (int i = 0; i < N; i++) begin
        if (wen_i[i] && dest[i] == SLOT_W'(j)) word = lane_data_i[i*W +: W];
      end
    end
    assign buf_o[j*W +: W] = word;
  end
endmodule

// File: rtl/cso_flush.sv
module cso_flush
  import cso_pkg::*;
#(
  parameter int N      = 4,
  parameter int W      = 8,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               fin_i,
  input  logic [W-1:0]       null_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [2*N*W-1:0]   buf_nxt_i,
  output logic [SLOT_W-1:0]  ptr_o,
  output logic [2*N*W-1:0]   buf_o,
  output logic               we_o,
  output logic [N*W-1:0]     data_o,
  output logic               done_o,
  output logic               done_nxt_o,
  output logic               pend_o
);
  localparam int HALF_W = SLOT_W - 1;
  localparam int ROW_W  = N * W;

  logic [SLOT_W-1:0] ptr_q, ptr_adv, sum_low;
  logic [HALF_W-1:0] rem;
  logic              old_side, cur_side, fills, need_pad, split;
  logic [ROW_W-1:0]  full_row, cur_row, pad_row, pend_row_q;
  logic [2*ROW_W-1:0] buf_q;
  logic              pend_q;
  flush_e            kind;

  assign old_side = ptr_q[SLOT_W-1];
  assign sum_low  = {1'b0, ptr_q[HALF_W-1:0]} + SLOT_W'(cnt_i);
  assign fills    = acc_i && sum_low[SLOT_W-1];
  assign ptr_adv  = acc_i ? ptr_q + SLOT_W'(cnt_i) : ptr_q;
  assign rem      = ptr_adv[HALF_W-1:0];
  assign cur_side = ptr_adv[SLOT_W-1];
  assign need_pad = fin_i && (rem != '0);
  assign split    = !pend_q && fills && need_pad;

  assign full_row = old_side ? buf_nxt_i[ROW_W +: ROW_W] : buf_nxt_i[0 +: ROW_W];
  assign cur_row  = cur_side ? buf_nxt_i[ROW_W +: ROW_W] : buf_nxt_i[0 +: ROW_W];

  for (genvar k = 0; k < N; k++) begin : g_pad
    assign pad_row[k*W +: W] = (HALF_W'(k) < rem) ? cur_row[k*W +: W] : null_i;
  end

  always_comb begin
    kind = FL_IDLE;
    if (pend_q)        kind = FL_TAIL;
    else if (fills)    kind = FL_FULL;
    else if (need_pad) kind = FL_PAD;
  end

  assign done_nxt_o = pend_q || (fin_i && !split);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      buf_q      <= '0;
      pend_q     <= 1'b0;
      pend_row_q <= '0;
      we_o       <= 1'b0;
      data_o     <= '0;
      done_o     <= 1'b0;
    end else begin
      buf_q  <= buf_nxt_i;
      ptr_q  <= fin_i ? '0 : ptr_adv;
      pend_q <= split;
      if (split) pend_row_q <= pad_row;
      we_o   <= (kind != FL_IDLE);
      done_o <= done_nxt_o;
      unique case (kind)
        FL_FULL: data_o <= full_row;
        FL_PAD:  data_o <= pad_row;
        FL_TAIL: data_o <= pend_row_q;
        default: data_o <= data_o;
      endcase
    end
  end

  assign ptr_o  = ptr_q;
  assign buf_o  = buf_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cso_compressor.sv
module cso_compressor #(
  parameter int NUM_LANES = 4,
  parameter int DATA_W    = 8,
  parameter int TOTAL_W   = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [NUM_LANES-1:0]        wen_i,
  input  logic [NUM_LANES*DATA_W-1:0] lane_data_i,
  input  logic                        finish_i,
  input  logic [DATA_W-1:0]           null_val_i,
  output logic                        stream_we_o,
  output logic [NUM_LANES*DATA_W-1:0] stream_data_o,
  output logic                        done_o,
  output logic [TOTAL_W-1:0]          total_o
);
  localparam int SLOT_W = $clog2(2 * NUM_LANES);
  localparam int RANK_W = $clog2(NUM_LANES);
  localparam int CNT_W  = $clog2(NUM_LANES + 1);
  localparam int ROW_W  = NUM_LANES * DATA_W;

  logic                   busy_q, acc, fin_acc;
  logic                   s1_valid_q, s1_fin_q;
  logic [NUM_LANES-1:0]   s1_wen_q, wen_g;
  logic [ROW_W-1:0]       s1_data_q;
  logic [DATA_W-1:0]      s1_null_q;
  logic [NUM_LANES*RANK_W-1:0] rank_w, s1_rank_q;
  logic [CNT_W-1:0]       cnt_w, s1_cnt_q;
  logic [SLOT_W-1:0]      ptr_w;
  logic [2*ROW_W-1:0]     buf_w, buf_nxt_w;
  logic                   done_nxt_w, pend_w, restart_q;

  assign acc     = valid_i && !busy_q;
  assign fin_acc = finish_i && !busy_q;
  assign wen_g   = acc ? wen_i : '0;

  cso_rank #(.N(NUM_LANES), .RANK_W(RANK_W), .CNT_W(CNT_W)) u_rank (
    .wen_i (wen_g),
    .rank_o(rank_w),
    .cnt_o (cnt_w)
  );

  // control-generation stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_fin_q   <= 1'b0;
      s1_wen_q   <= '0;
      s1_data_q  <= '0;
      s1_null_q  <= '0;
      s1_rank_q  <= '0;
      s1_cnt_q   <= '0;
      busy_q     <= 1'b0;
    end else begin
      s1_valid_q <= acc;
      s1_fin_q   <= fin_acc;
      s1_wen_q   <= wen_g;
      s1_data_q  <= lane_data_i;
      s1_null_q  <= null_val_i;
      s1_rank_q  <= rank_w;
      s1_cnt_q   <= cnt_w;
      if (fin_acc)         busy_q <= 1'b1;
      else if (done_nxt_w) busy_q <= 1'b0;
    end
  end

  cso_xbar #(.N(NUM_LANES), .W(DATA_W), .SLOT_W(SLOT_W), .RANK_W(RANK_W)) u_xbar (
    .ptr_i      (ptr_w),
    .wen_i      (s1_wen_q),
    .rank_i     (s1_rank_q),
    .lane_data_i(s1_data_q),
    .buf_i      (buf_w),
    .buf_o      (buf_nxt_w)
  );

  cso_flush #(.N(NUM_LANES), .W(DATA_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_flush (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (s1_valid_q),
    .fin_i     (s1_fin_q),
    .null_i    (s1_null_q),
    .cnt_i     (s1_cnt_q),
    .buf_nxt_i (buf_nxt_w),
    .ptr_o     (ptr_w),
    .buf_o     (buf_w),
    .we_o      (stream_we_o),
    .data_o    (stream_data_o),
    .done_o    (done_o),
    .done_nxt_o(done_nxt_w),
    .pend_o    (pend_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_o   <= '0;
      restart_q <= 1'b0;
    end else begin
      if (s1_valid_q) total_o <= (restart_q ? '0 : total_o) + TOTAL_W'(s1_cnt_q);
      if (done_nxt_w)      restart_q <= 1'b1;
      else if (s1_valid_q) restart_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cso_checker.sv
module cso_checker #(
  parameter int NUM_LANES = 4,
  parameter int TOTAL_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               finish_i,
  input logic               busy_i,
  input logic               s1_valid_i,
  input logic               s1_fin_i,
  input logic               pend_i,
  input logic               done_i,
  input logic               we_i,
  input logic [TOTAL_W-1:0] total_i
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_tail_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |=> (done_i && we_i));

  assert_drain_time_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && !busy_i) |=> ##1 (done_i || pend_i));

  assert_no_idle_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!s1_valid_i && !s1_fin_i && !pend_i) |=> !we_i);

  assert_total_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_i |=> $stable(total_i));

  assert_total_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_i |=> (total_i <= $past(total_i) + TOTAL_W'(NUM_LANES)));
endmodule

bind cso_compressor cso_checker #(.NUM_LANES(NUM_LANES), .TOTAL_W(TOTAL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .finish_i  (finish_i),
  .busy_i    (busy_q),
  .s1_valid_i(s1_valid_q),
  .s1_fin_i  (s1_fin_q),
  .pend_i    (pend_w),
  .done_i    (done_o),
  .we_i      (stream_we_o),
  .total_i   (total_o)
);

// File: tb/tb_cso_compressor.sv
module tb_cso_compressor;
  localparam int N = 4;
  localparam int W = 8;
  localparam int TW = 16;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [N-1:0]   wen_i = '0;
  logic [N*W-1:0] lane_data_i = '0;
  logic           finish_i = 1'b0;
  logic [W-1:0]   null_val_i = '0;
  logic           stream_we_o;
  logic [N*W-1:0] stream_data_o;
  logic           done_o;
  logic [TW-1:0]  total_o;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  int finishes = 0;
  int scnt = 0;
  logic [W-1:0] dseq = 8'h01;
  logic [W-1:0] exp_q[$];

  always #2.5 clk_i = ~clk_i;

  cso_compressor #(.NUM_LANES(N), .DATA_W(W), .TOTAL_W(TW)) dut (.*);

  function automatic int popc(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output monitor: compares each wide write against the expected word queue
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (stream_we_o) begin
        for (int k = 0; k < N; k++) begin
          logic [W-1:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
          check(stream_data_o[k*W +: W] === e, "R2 R5 R7 stream word",
                int'(stream_data_o[k*W +: W]), int'(e));
        end
      end
      if (done_o) begin
        done_seen++;
        check(exp_q.size() == 0, "R8 done before final write", exp_q.size(), 0);
      end
    end
  end

  // called just after a negedge; returns at the next negedge
  task automatic drive(input bit v, input logic [N-1:0] m, input bit f,
                       input logic [W-1:0] nul, input bit push);
    valid_i = v;
    wen_i = m;
    finish_i = f;
    null_val_i = nul;
    for (int i = 0; i < N; i++) lane_data_i[i*W +: W] = dseq + W'(i);
    if (push && v) begin
      for (int i = 0; i < N; i++) if (m[i]) begin
        exp_q.push_back(dseq + W'(i));
        scnt++;
      end
    end
    if (push && f) begin
      for (int i = 0; i < (N - scnt % N) % N; i++) exp_q.push_back(nul);
      scnt = 0;
      finishes++;
    end
    if (v) dseq = dseq + W'(N);
    @(negedge clk_i);
    valid_i = 1'b0;
    finish_i = 1'b0;
    wen_i = '0;
  endtask

  task automatic wait_done(input int exp_tot, input string tag);
    int w = 0;
    while (!done_o && w < 12) begin
      drive(1'b0, '0, 1'b0, '0, 1'b1);
      w++;
    end
    check(done_o === 1'b1, "R5 done within window", int'(done_o), 1);
    check(total_o == TW'(exp_tot), tag, int'(total_o), exp_tot);
    drive(1'b0, '0, 1'b0, '0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(stream_we_o === 1'b0, "R1 we after reset", int'(stream_we_o), 0);
    check(done_o === 1'b0, "R1 done after reset", int'(done_o), 0);
    check(total_o === '0, "R1 total after reset", int'(total_o), 0);

    // R3 latency and R4 single-cycle write
    drive(1'b1, 4'hF, 1'b0, 8'hEE, 1'b1);
    check(stream_we_o === 1'b0, "R3 no write after one edge", int'(stream_we_o), 0);
    drive(1'b0, '0, 1'b0, '0, 1'b1);
    check(stream_we_o === 1'b1, "R3 write after two edges", int'(stream_we_o), 1);
    drive(1'b0, '0, 1'b0, '0, 1'b1);
    check(stream_we_o === 1'b0, "R4 write lasts one cycle", int'(stream_we_o), 0);

    // R6 finish with empty side: done alone
    drive(1'b0, '0, 1'b1, 8'hEE, 1'b1);
    while (!done_o) drive(1'b0, '0, 1'b0, '0, 1'b1);
    check(stream_we_o === 1'b0, "R6 no padded write on empty side", int'(stream_we_o), 0);
    check(total_o == TW'(4), "R9 total after stream", int'(total_o), 4);
    drive(1'b0, '0, 1'b0, '0, 1'b1);

    // sweep: every mask pair, finish separate or concurrent, junk during drain (R10)
    for (int mode = 0; mode < 2; mode++) begin
      for (int ma = 0; ma < 16; ma++) begin
        for (int mb = 0; mb < 16; mb++) begin
          logic [W-1:0] nul;
          nul = W'(8'hC0 + ma + mb);
          drive(1'b1, N'(ma), 1'b0, nul, 1'b1);
          if (mode == 0) begin
            drive(1'b1, N'(mb), 1'b0, nul, 1'b1);
            drive(1'b0, '0, 1'b0, nul, 1'b1);
            drive(1'b0, '0, 1'b1, nul, 1'b1);
          end else begin
            drive(1'b1, N'(mb), 1'b1, nul, 1'b1); // R7 concurrent finish
          end
          // R10: this access and finish arrive while draining and must be dropped
          drive(1'b1, 4'hF, 1'b1, 8'h55, 1'b0);
          wait_done(popc(N'(ma)) + popc(N'(mb)),
                    (ma == 0 || mb == 0) ? "R11 total with empty access" : "R9 total");
        end
      end
    end

    check(done_seen == finishes, "R8 one done per finish", done_seen, finishes);
    check(exp_q.size() == 0, "R10 R2 stray expected words", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule